// File: doc/BRIEF.md
# Processor Control Pin Event Controller

This block watches the external control pins of a processor core and turns their changes into events the core can use. Four of those events become bits of a pending-interrupt vector: external interrupt, system management interrupt, machine check and soft reset. Any set bit raises one combined request line to the core. The three remaining pins do not set pending bits. They drive dedicated outputs instead: a core stop flag for checkstop, a one-cycle reset request for hard reset, and a run flag for the time base.

The pins are taken as already synchronous to the core clock. The block keeps a registered copy of each pin's last level and acts only when a pin differs from that copy. Each pin has its own active sense and its own kind of sensitivity. Machine check reacts to a falling edge and stays pending until the core acknowledges it by index. The interrupt-type pins and soft reset follow their level. Checkstop stops the core when it falls, and only a falling hard reset releases it. All outputs are registered. An output changes at the clock edge that first samples the new pin level.

Top module: `irqpin_ctrl`

## Requirements
- R1: Each pin's last sampled level is stored, and a pin acts only when its new level differs from the stored one. Repeating a level produces no event. Block reset clears every stored level to 0, so a pin that is low when reset is released produces no event.
- R2: The external interrupt pin drives pending bit 0 and the system management pin drives pending bit 1. Both are active high, and each bit follows its pin (set when the pin rises, cleared when it falls).
- R3: A 1-to-0 change on the machine check pin sets pending bit 2. A later rise of the pin leaves the bit set.
- R4: A falling change on the active-low checkstop pin sets `core_stop_o`. A rise of checkstop does not clear it. Only a falling change on hard reset clears it, and when both pins fall in the same cycle, `core_stop_o` ends up 0.
- R5: A falling change on the active-low hard reset pin gives exactly one cycle of `core_rst_req_o`. Holding the pin low gives no further pulse.
- R6: The soft reset pin drives pending bit 3 and follows its level, active high.
- R7: `tb_run_o` follows the time-base enable pin. High lets the time base count and low freezes it.
- R8: `core_irq_o` is high whenever any pending bit is set, and low only when all four bits are zero.
- R9: An acknowledge (`ack_valid_i` high with `ack_idx_i` = 2) clears the sticky machine check bit. An acknowledge naming a level-following bit (0, 1 or 3) has no effect. If a machine check falling edge arrives in the same cycle as its acknowledge, the bit stays set.
- R10: Block reset clears the pending vector and drives `core_irq_o`, `core_stop_o`, `core_rst_req_o` and `tb_run_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high block reset |
| ext_irq_i | input | 1 | External interrupt pin, active high, level |
| smi_i | input | 1 | System management interrupt pin, active high, level |
| mchk_i | input | 1 | Machine check pin, falling-edge sensitive |
| chkstop_n_i | input | 1 | Checkstop pin, active low |
| hreset_n_i | input | 1 | Hard reset pin, active low |
| sreset_i | input | 1 | Soft reset pin, active high, level |
| tben_i | input | 1 | Time-base enable pin, active high, level |
| ack_valid_i | input | 1 | One-cycle acknowledge strobe from the core |
| ack_idx_i | input | 2 | Pending bit index being acknowledged |
| pend_o | output | 4 | Pending vector: bit 0 ext, 1 smi, 2 machine check, 3 soft reset |
| core_irq_o | output | 1 | Combined interrupt request |
| core_stop_o | output | 1 | Core held stopped |
| core_rst_req_o | output | 1 | One-cycle core reset request |
| tb_run_o | output | 1 | Time base allowed to count |

## Verification
Two pairs of events can land in the same cycle. In the first, a machine check falling edge meets an acknowledge of that same bit. In the second, checkstop and hard reset fall together. The vector table drives each pair in a single cycle. It then judges the results at the next sample: the pending bit must stay set, which shows the set wins over the acknowledge, and `core_stop_o` must read 0 while `core_rst_req_o` pulses, which shows hard reset wins. A follow-on cycle then shows that the surviving state behaves normally: the bit clears on a later acknowledge, and the stop output stays low.

// File: rtl/irqpin_pkg.sv
package irqpin_pkg;
  // Pin positions inside the sampled pin vector
  localparam int NUM_PINS   = 7;
  localparam int PIN_EXT    = 0;
  localparam int PIN_SMI    = 1;
  localparam int PIN_MCHK   = 2;
  localparam int PIN_CSTOP  = 3;
  localparam int PIN_HRST   = 4;
  localparam int PIN_SRST   = 5;
  localparam int PIN_TBEN   = 6;

  // Pending vector layout
  localparam int PEND_W     = 4;
  localparam int ACK_W      = $clog2(PEND_W);
  localparam int BIT_EXT    = 0;
  localparam int BIT_SMI    = 1;
  localparam int BIT_MCHK   = 2;
  localparam int BIT_SRST   = 3;

  // Bits that hold until acknowledged; the rest follow their pin
  localparam logic [PEND_W-1:0] STICKY_MASK = 4'b0100;
endpackage

// File: rtl/pin_edge_track.sv
module pin_edge_track #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pins_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] last_q;

  always_ff @(posedge clk) begin
    if (rst) last_q <= '0;
    else     last_q <= pins_i;
  end

  always_comb begin
    rise_o = pins_i & ~last_q;
    fall_o = ~pins_i & last_q;
  end
endmodule

// File: rtl/pend_bank.sv
module pend_bank #(
  parameter int              W      = 4,
  parameter int              AW     = 2,
  parameter logic [W-1:0]    STICKY = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  set_i,
  input  logic [W-1:0]  clr_i,
  input  logic          ack_valid_i,
  input  logic [AW-1:0] ack_idx_i,
  output logic [W-1:0]  pend_q,
  output logic          any_q
);
  logic [W-1:0] pend_nxt;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (STICKY[i]) begin : g_sticky
      logic ack_hit;
      assign ack_hit = ack_valid_i && (ack_idx_i == AW'(i));
      always_comb begin
        if (set_i[i])     pend_nxt[i] = 1'b1;
        else if (ack_hit) pend_nxt[i] = 1'b0;
        else              pend_nxt[i] = pend_q[i];
      end
    end else begin : g_level
      always_comb begin
        if (set_i[i])      pend_nxt[i] = 1'b1;
        else if (clr_i[i]) pend_nxt[i] = 1'b0;
        else               pend_nxt[i] = pend_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      any_q  <= 1'b0;
    end else begin
      pend_q <= pend_nxt;
      any_q  <= |pend_nxt;
    end
  end
endmodule

// File: rtl/core_ctl.sv
module core_ctl (
  input  logic clk,
  input  logic rst,
  input  logic cstop_fall_i,
  input  logic hrst_fall_i,
  input  logic tb_rise_i,
  input  logic tb_fall_i,
  output logic stop_q,
  output logic rreq_q,
  output logic tb_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stop_q <= 1'b0;
      rreq_q <= 1'b0;
      tb_q   <= 1'b0;
    end else begin
      // hard reset is the only way out of a stop, and wins a tie
      if (hrst_fall_i)       stop_q <= 1'b0;
      else if (cstop_fall_i) stop_q <= 1'b1;
      rreq_q <= hrst_fall_i;
      if (tb_rise_i)      tb_q <= 1'b1;
      else if (tb_fall_i) tb_q <= 1'b0;
    end
  end
endmodule

// File: rtl/irqpin_ctrl.sv
module irqpin_ctrl
  import irqpin_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_irq_i,
  input  logic              smi_i,
  input  logic              mchk_i,
  input  logic              chkstop_n_i,
  input  logic              hreset_n_i,
  input  logic              sreset_i,
  input  logic              tben_i,
  input  logic              ack_valid_i,
  input  logic [ACK_W-1:0]  ack_idx_i,
  output logic [PEND_W-1:0] pend_o,
  output logic              core_irq_o,
  output logic              core_stop_o,
  output logic              core_rst_req_o,
  output logic              tb_run_o
);
  logic [NUM_PINS-1:0] pins;
  logic [NUM_PINS-1:0] rise;
  logic [NUM_PINS-1:0] fall;
  logic [PEND_W-1:0]   pset;
  logic [PEND_W-1:0]   pclr;

  always_comb begin
    pins            = '0;
    pins[PIN_EXT]   = ext_irq_i;
    pins[PIN_SMI]   = smi_i;
    pins[PIN_MCHK]  = mchk_i;
    pins[PIN_CSTOP] = chkstop_n_i;
    pins[PIN_HRST]  = hreset_n_i;
    pins[PIN_SRST]  = sreset_i;
    pins[PIN_TBEN]  = tben_i;
  end

  pin_edge_track #(.W(NUM_PINS)) u_track (
    .clk    (clk),
    .rst    (rst),
    .pins_i (pins),
    .rise_o (rise),
    .fall_o (fall)
  );

  always_comb begin
    pset           = '0;
    pclr           = '0;
    pset[BIT_EXT]  = rise[PIN_EXT];
    pclr[BIT_EXT]  = fall[PIN_EXT];
    pset[BIT_SMI]  = rise[PIN_SMI];
    pclr[BIT_SMI]  = fall[PIN_SMI];
    pset[BIT_MCHK] = fall[PIN_MCHK];
    pset[BIT_SRST] = rise[PIN_SRST];
    pclr[BIT_SRST] = fall[PIN_SRST];
  end

  pend_bank #(.W(PEND_W), .AW(ACK_W), .STICKY(STICKY_MASK)) u_pend (
    .clk         (clk),
    .rst         (rst),
    .set_i       (pset),
    .clr_i       (pclr),
    .ack_valid_i (ack_valid_i),
    .ack_idx_i   (ack_idx_i),
    .pend_q      (pend_o),
    .any_q       (core_irq_o)
  );

  core_ctl u_ctl (
    .clk          (clk),
    .rst          (rst),
    .cstop_fall_i (fall[PIN_CSTOP]),
    .hrst_fall_i  (fall[PIN_HRST]),
    .tb_rise_i    (rise[PIN_TBEN]),
    .tb_fall_i    (fall[PIN_TBEN]),
    .stop_q       (core_stop_o),
    .rreq_q       (core_rst_req_o),
    .tb_q         (tb_run_o)
  );
endmodule

// File: rtl/irqpin_ctrl_chk.sv
module irqpin_ctrl_chk
  import irqpin_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              ext_irq_i,
  input logic              smi_i,
  input logic              mchk_i,
  input logic              chkstop_n_i,
  input logic              hreset_n_i,
  input logic              sreset_i,
  input logic              tben_i,
  input logic              ack_valid_i,
  input logic [ACK_W-1:0]  ack_idx_i,
  input logic [PEND_W-1:0] pend_o,
  input logic              core_irq_o,
  input logic              core_stop_o,
  input logic              core_rst_req_o,
  input logic              tb_run_o
);
  logic warm;
  logic [NUM_PINS-1:0] pv;
  assign pv = {tben_i, sreset_i, hreset_n_i, chkstop_n_i, mchk_i, smi_i, ext_irq_i};

  always_ff @(posedge clk) begin
    if (rst) warm <= 1'b0;
    else     warm <= 1'b1;
  end

  AST_NO_CHANGE_NO_EVENT: assert property (@(posedge clk) disable iff (rst || !warm)
    (pv == $past(pv) && !ack_valid_i) |=> $stable(pend_o)); // R1

  AST_MCHK_STICKY: assert property (@(posedge clk) disable iff (rst)
    (pend_o[BIT_MCHK] && !(ack_valid_i && ack_idx_i == ACK_W'(BIT_MCHK))) |=> pend_o[BIT_MCHK]); // R3

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $fell(core_stop_o) |-> core_rst_req_o); // R4

  AST_RREQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    core_rst_req_o |=> !core_rst_req_o); // R5

  AST_TB_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (tb_run_o == $past(tben_i))); // R7

  AST_IRQ_ANY: assert property (@(posedge clk) disable iff (rst)
    core_irq_o == (pend_o != '0)); // R8

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst || !warm)
    (ack_valid_i && ack_idx_i == ACK_W'(BIT_MCHK) && !(!mchk_i && $past(mchk_i)))
      |=> !pend_o[BIT_MCHK]); // R9
endmodule

bind irqpin_ctrl irqpin_ctrl_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .ext_irq_i      (ext_irq_i),
  .smi_i          (smi_i),
  .mchk_i         (mchk_i),
  .chkstop_n_i    (chkstop_n_i),
  .hreset_n_i     (hreset_n_i),
  .sreset_i       (sreset_i),
  .tben_i         (tben_i),
  .ack_valid_i    (ack_valid_i),
  .ack_idx_i      (ack_idx_i),
  .pend_o         (pend_o),
  .core_irq_o     (core_irq_o),
  .core_stop_o    (core_stop_o),
  .core_rst_req_o (core_rst_req_o),
  .tb_run_o       (tb_run_o)
);

// File: tb/irqpin_ctrl_bench.sv
module irqpin_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 27;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ext_irq, smi, mchk, cstop_n, hrst_n, srst, tben, ackv;
  logic [1:0] acki;
  logic [3:0] pend;
  logic       irq, stop, rreq, tbrun;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqpin_ctrl u_irqpin_ctrl (
    .clk(clk), .rst(rst), .ext_irq_i(ext_irq), .smi_i(smi), .mchk_i(mchk),
    .chkstop_n_i(cstop_n), .hreset_n_i(hrst_n), .sreset_i(srst), .tben_i(tben),
    .ack_valid_i(ackv), .ack_idx_i(acki), .pend_o(pend), .core_irq_o(irq),
    .core_stop_o(stop), .core_rst_req_o(rreq), .tb_run_o(tbrun)
  );

  // {pins tb,sr,hr_n,cs_n,mc,smi,ext | ackv | acki | pend[3:0] | irq stop rreq tb}
  localparam logic [17:0] VECS [0:NV-1] = '{
    {7'b0011100, 1'b0, 2'd0, 4'b0000, 4'b0000}, // idle after reset, R1
    {7'b0011101, 1'b0, 2'd0, 4'b0001, 4'b1000}, // ext rises R2
    {7'b0011101, 1'b0, 2'd0, 4'b0001, 4'b1000}, // repeat level R1
    {7'b0011110, 1'b0, 2'd0, 4'b0010, 4'b1000}, // ext drops, smi rises R2
    {7'b0011100, 1'b0, 2'd0, 4'b0000, 4'b0000}, // smi drops R8
    {7'b0011000, 1'b0, 2'd0, 4'b0100, 4'b1000}, // mchk falls R3
    {7'b0011100, 1'b0, 2'd0, 4'b0100, 4'b1000}, // mchk rises, sticky R3
    {7'b0011100, 1'b1, 2'd0, 4'b0100, 4'b1000}, // ack level bit ignored R9
    {7'b0011100, 1'b1, 2'd2, 4'b0000, 4'b0000}, // ack mchk R9
    {7'b0111100, 1'b0, 2'd0, 4'b1000, 4'b1000}, // sreset high R6
    {7'b0011100, 1'b0, 2'd0, 4'b0000, 4'b0000}, // sreset low R6
    {7'b1011100, 1'b0, 2'd0, 4'b0000, 4'b0001}, // tben high R7
    {7'b1011100, 1'b0, 2'd0, 4'b0000, 4'b0001}, // tben held R7
    {7'b0011100, 1'b0, 2'd0, 4'b0000, 4'b0000}, // tben low freezes R7
    {7'b0010100, 1'b0, 2'd0, 4'b0000, 4'b0100}, // checkstop low R4
    {7'b0011100, 1'b0, 2'd0, 4'b0000, 4'b0100}, // checkstop high, still stopped R4
    {7'b0001100, 1'b0, 2'd0, 4'b0000, 4'b0010}, // hreset low: restart, request R4 R5
    {7'b0001100, 1'b0, 2'd0, 4'b0000, 4'b0000}, // hreset held, no repeat R5
    {7'b0011100, 1'b0, 2'd0, 4'b0000, 4'b0000}, // hreset high
    {7'b0011000, 1'b1, 2'd2, 4'b0100, 4'b1000}, // mchk fall with ack: set wins R9
    {7'b0011100, 1'b1, 2'd2, 4'b0000, 4'b0000}, // later ack clears R9
    {7'b0000100, 1'b0, 2'd0, 4'b0000, 4'b0010}, // checkstop+hreset same cycle R4
    {7'b0011100, 1'b0, 2'd0, 4'b0000, 4'b0000}, // both back high, stop stays 0 R4
    {7'b0111001, 1'b0, 2'd0, 4'b1101, 4'b1000}, // ext, mchk fall, sreset together
    {7'b0011000, 1'b0, 2'd0, 4'b0100, 4'b1000}, // level bits drop, mchk kept R3
    {7'b0011100, 1'b1, 2'd3, 4'b0100, 4'b1000}, // ack of sreset bit ignored R9
    {7'b0011100, 1'b1, 2'd2, 4'b0000, 4'b0000}  // ack mchk R9
  };

  task automatic drive(input logic [6:0] p, input logic av, input logic [1:0] ai);
    {tben, srst, hrst_n, cstop_n, mchk, smi, ext_irq} = p;
    ackv = av;
    acki = ai;
  endtask

  task automatic check(input string req, input logic [3:0] ep, input logic [3:0] eo);
    vectors++;
    if (pend !== ep || {irq, stop, rreq, tbrun} !== eo) begin
      miscompares++;
      $display("FAIL %s: pend=%b irq/stop/rreq/tb=%b expected pend=%b irq/stop/rreq/tb=%b",
               req, pend, {irq, stop, rreq, tbrun}, ep, eo);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    drive(7'b0011100, 1'b0, 2'd0);
    repeat (3) @(negedge clk);
    check("R10 reset state", 4'b0000, 4'b0000);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i][17:11], VECS[i][10], VECS[i][9:8]);
      @(negedge clk);
      check($sformatf("vector %0d (R1 R2 R3 R4 R5 R6 R7 R8 R9)", i), VECS[i][7:4], VECS[i][3:0]);
    end

    // Directed: build state, then reset mid-run (R10)
    drive(7'b1010000, 1'b0, 2'd0);   // tben high, checkstop low, mchk low
    @(negedge clk);
    drive(7'b1010001, 1'b0, 2'd0);   // ext high as well
    @(negedge clk);
    check("R10 pre-reset state built", 4'b0101, 4'b1101);
    rst = 1'b1;
    @(negedge clk);
    check("R10 reset clears outputs", 4'b0000, 4'b0000);
    // release with ext low, checkstop and mchk held low: stored zeros, no event (R1)
    drive(7'b0010000, 1'b0, 2'd0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 low pins at release give no event", 4'b0000, 4'b0000);
    drive(7'b0011000, 1'b0, 2'd0);   // checkstop rises
    @(negedge clk);
    check("R4 checkstop rise only", 4'b0000, 4'b0000);
    drive(7'b0010000, 1'b0, 2'd0);   // checkstop falls
    @(negedge clk);
    check("R4 checkstop fall stops", 4'b0000, 4'b0100);
    drive(7'b0000000, 1'b0, 2'd0);   // hreset low: stored was 1 from release? stored 1 -> falls
    @(negedge clk);
    check("R5 hreset fall releases", 4'b0000, 4'b0010);
    finish_run();
  end

  initial begin
    int cyc = 0;
    while (cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    miscompares++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    finish_run();
  end
endmodule